// File: doc/BRIEF.md
# Single-Accumulator Fetch-Execute Controller

This block is the control unit and datapath of a small 16-bit machine with one accumulator and one address per instruction. Its registers are a program counter, an accumulator, a memory address register, an instruction register, a data register and a two-bit flag register (zero and carry). It talks to memory through a single port. Every clock state performs exactly one register-transfer step, and all memory traffic goes through the address and data registers. A read returns data in the cycle after the address register has been loaded. A write happens on the clock edge that ends the write state.

Each instruction is fetched in three states and decoded from the data register in the last of them. An optional indirect step then replaces the address field of the instruction register with a word read from memory. The execute states follow. The last state of every instruction also looks at the interrupt request. A level-sensitive request that is seen while interrupts are enabled is serviced between instructions. The return address is written to a fixed save word through the data register, and fetching continues at a fixed service entry. A service routine returns with an indirect jump through the save word.

States and transitions. Fetch: `S_F_MAR` goes to `S_F_READ`, then to `S_F_IR`. From `S_F_IR`:
- NOP or an unassigned opcode goes to the instruction end.
- EI goes to `S_X_ENINT`.
- An addressed opcode with the indirect bit set goes to `S_I_MAR`.
- A data opcode goes to `S_X_MAR`.
- A jump goes to `S_X_BRANCH`.

Indirect: `S_I_MAR` goes to `S_I_READ`, then `S_I_IR`, then to `S_X_MAR` for data opcodes or `S_X_BRANCH` for jumps.

Execute: `S_X_MAR` goes to `S_X_WRITE` for STORE, otherwise to `S_X_READ`. `S_X_READ` goes to `S_X_LOAD` for LOAD or `S_X_ADD` for ADD. `S_X_LOAD`, `S_X_ADD`, `S_X_WRITE`, `S_X_BRANCH`, `S_X_ENINT` and the NOP path all end the instruction. The instruction end goes to `S_V_DR` when the request is high and interrupts are enabled, otherwise to `S_F_MAR`.

Entry: `S_V_DR` goes to `S_V_MAR`, then `S_V_WRITE`, then `S_V_PC`, then `S_F_MAR`.

Top module: `accum_seq_core`

## Requirements
- R1: While rst_n is low no memory write occurs. Reset clears the accumulator, both flags and the interrupt enable. On the first rising edge after release the address register takes the boot address 0x020, so mem_addr shows 0x020 after that edge.
- R2: An instruction word holds the opcode in bits 15..12, the indirect flag in bit 11 and an address in bits 10..0. Fetch takes three states, in this order: address←PC; data←memory together with PC+1; instruction←data. A direct STORE at the boot address writes on the 5th rising edge after reset release.
- R3: LOAD (opcode 1) copies the memory word into the accumulator. It sets zero exactly when that word is 0 and always clears carry.
- R4: ADD (opcode 3) adds the memory word to the accumulator modulo 2^16. Carry is the bit-16 carry out, and zero is set when the 16-bit result is 0.
- R5: STORE (opcode 2) writes the accumulator to the addressed word. The write strobe stays high for exactly one cycle, and the flags are left unchanged.
- R6: When bit 11 is set, the effective address is the low 11 bits of the word at the address field. This costs exactly three extra cycles and applies to LOAD, ADD, STORE and all jumps.
- R7: JMP (opcode 4) always loads PC with the effective address. JZ (opcode 5) does so only when zero is set, and JC (opcode 6) only when carry is set.
- R8: At the end of an instruction with irq high and interrupts enabled, the address of the next instruction is written to word 0x002. Fetching then resumes at 0x010.
- R9: The interrupt enable is cleared at reset and on interrupt entry, and set by EI (opcode 7). The check at the end of EI uses the value from before EI, so the earliest entry follows the instruction after EI. While the enable is clear, irq is ignored.
- R10: NOP (opcode 0) and the unassigned opcodes 8 to 15 take only the three fetch cycles, whatever the indirect bit holds. They change no register other than PC and write no memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Level-sensitive interrupt request |
| mem_addr | output | 11 | Memory address, the address register |
| mem_rdata | input | 16 | Read data for mem_addr, valid in the cycle after the address is loaded |
| mem_wdata | output | 16 | Write data (accumulator, or data register on interrupt entry) |
| mem_we | output | 1 | Write strobe, the word is written at the rising edge |

## Verification
The assertions check on every cycle:
- the fixed order of the fetch states;
- that the indirect step changes only the address field of the instruction register;
- that LOAD leaves carry clear and that every write lasts a single cycle;
- that interrupt entry starts only with the enable set, clears it, and writes to the save word.

Only the bench scenarios can show the arithmetic results and flags of the sweep over operand pairs, the branch decisions and the exact cycle on which a write lands. The same holds for the one-instruction delay after EI, the return through the saved word and the absence of effect from NOP and unassigned opcodes.

// File: rtl/accum_seq_pkg.sv
`timescale 1ns/1ps
package accum_seq_pkg;

    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 4'h0,
        OP_LOAD  = 4'h1,
        OP_STORE = 4'h2,
        OP_ADD   = 4'h3,
        OP_JMP   = 4'h4,
        OP_JZ    = 4'h5,
        OP_JC    = 4'h6,
        OP_EI    = 4'h7
    } opcode_e;

    typedef enum logic [4:0] {
        S_F_MAR, S_F_READ, S_F_IR,
        S_I_MAR, S_I_READ, S_I_IR,
        S_X_MAR, S_X_READ, S_X_LOAD, S_X_ADD, S_X_WRITE, S_X_BRANCH, S_X_ENINT,
        S_V_DR, S_V_MAR, S_V_WRITE, S_V_PC
    } state_e;

    typedef enum logic [2:0] {
        MAR_KEEP, MAR_FROM_PC, MAR_FROM_DR, MAR_FROM_IR, MAR_FROM_SAVE
    } mar_src_e;

    // One register-transfer step per field; the controller raises a few per state.
    typedef struct packed {
        mar_src_e mar_src;
        logic     dr_from_mem;
        logic     dr_from_pc;
        logic     pc_step;
        logic     pc_jump;
        logic     pc_vector;
        logic     ir_load;
        logic     ir_addr_load;
        logic     ac_from_dr;
        logic     ac_from_sum;
        logic     mem_we;
        logic     wdata_from_dr;
        logic     ie_set;
        logic     ie_clr;
    } uop_t;

    function automatic logic is_data_op(input logic [OP_W-1:0] op);
        return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_ADD);
    endfunction

    function automatic logic is_jump_op(input logic [OP_W-1:0] op);
        return (op == OP_JMP) || (op == OP_JZ) || (op == OP_JC);
    endfunction

    function automatic logic needs_addr(input logic [OP_W-1:0] op);
        return is_data_op(op) || is_jump_op(op);
    endfunction

endpackage

// File: rtl/accum_seq_alu.sv
`timescale 1ns/1ps
module accum_seq_alu #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    input  logic              add_en,
    output logic [DATA_W-1:0] result,
    output logic              zero,
    output logic              carry
);

    logic [DATA_W:0] wide;

    always_comb begin
        wide = {1'b0, acc} + {1'b0, opnd};
        if (add_en) begin
            result = wide[DATA_W-1:0];
            carry  = wide[DATA_W];
        end else begin
            result = opnd;
            carry  = 1'b0;
        end
        zero = (result == '0);
    end

endmodule

// File: rtl/accum_seq_ctrl.sv
`timescale 1ns/1ps
module accum_seq_ctrl
    import accum_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq,
    input  logic [OP_W-1:0] dr_op,
    input  logic            dr_ind,
    input  logic [OP_W-1:0] ir_op,
    input  logic            zero_f,
    input  logic            carry_f,
    input  logic            int_en,
    output state_e          state,
    output uop_t            uop
);

    state_e state_nx;
    state_e end_nx;
    logic   take;

    // Interrupt check folded into the last state of each instruction.
    assign end_nx = (irq && int_en) ? S_V_DR : S_F_MAR;
    assign take   = (ir_op == OP_JMP) ||
                    ((ir_op == OP_JZ) && zero_f) ||
                    ((ir_op == OP_JC) && carry_f);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_F_MAR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = S_F_MAR;
        unique case (state)
            S_F_MAR:  state_nx = S_F_READ;
            S_F_READ: state_nx = S_F_IR;
            S_F_IR: begin
                if (!needs_addr(dr_op))
                    state_nx = (dr_op == OP_EI) ? S_X_ENINT : end_nx;
                else if (dr_ind)
                    state_nx = S_I_MAR;
                else if (is_data_op(dr_op))
                    state_nx = S_X_MAR;
                else
                    state_nx = S_X_BRANCH;
            end
            S_I_MAR:    state_nx = S_I_READ;
            S_I_READ:   state_nx = S_I_IR;
            S_I_IR:     state_nx = is_data_op(ir_op) ? S_X_MAR : S_X_BRANCH;
            S_X_MAR:    state_nx = (ir_op == OP_STORE) ? S_X_WRITE : S_X_READ;
            S_X_READ:   state_nx = (ir_op == OP_LOAD) ? S_X_LOAD : S_X_ADD;
            S_X_LOAD:   state_nx = end_nx;
            S_X_ADD:    state_nx = end_nx;
            S_X_WRITE:  state_nx = end_nx;
            S_X_BRANCH: state_nx = end_nx;
            S_X_ENINT:  state_nx = end_nx;
            S_V_DR:     state_nx = S_V_MAR;
            S_V_MAR:    state_nx = S_V_WRITE;
            S_V_WRITE:  state_nx = S_V_PC;
            S_V_PC:     state_nx = S_F_MAR;
            default:    state_nx = S_F_MAR;
        endcase
    end

    always_comb begin
        uop = '0;
        unique case (state)
            S_F_MAR:    uop.mar_src = MAR_FROM_PC;
            S_F_READ: begin
                uop.dr_from_mem = 1'b1;
                uop.pc_step     = 1'b1;
            end
            S_F_IR:     uop.ir_load = 1'b1;
            S_I_MAR:    uop.mar_src = MAR_FROM_DR;
            S_I_READ:   uop.dr_from_mem = 1'b1;
            S_I_IR:     uop.ir_addr_load = 1'b1;
            S_X_MAR:    uop.mar_src = MAR_FROM_IR;
            S_X_READ:   uop.dr_from_mem = 1'b1;
            S_X_LOAD:   uop.ac_from_dr = 1'b1;
            S_X_ADD:    uop.ac_from_sum = 1'b1;
            S_X_WRITE:  uop.mem_we = 1'b1;
            S_X_BRANCH: uop.pc_jump = take;
            S_X_ENINT:  uop.ie_set = 1'b1;
            S_V_DR: begin
                uop.dr_from_pc = 1'b1;
                uop.ie_clr     = 1'b1;
            end
            S_V_MAR:    uop.mar_src = MAR_FROM_SAVE;
            S_V_WRITE: begin
                uop.mem_we        = 1'b1;
                uop.wdata_from_dr = 1'b1;
            end
            S_V_PC:     uop.pc_vector = 1'b1;
            default:    uop = '0;
        endcase
    end

    // R2: fetch steps run strictly in order
    a_r2_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_F_IR) |-> ($past(state) == S_F_READ));

    // R9: entry only begins when the enable was set and a request was present
    a_r9_entry_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_V_DR) |-> ($past(int_en) && $past(irq)));

    // R9: enable already cleared when the vector is loaded
    a_r9_disabled_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_V_PC) |-> !int_en);

endmodule

// File: rtl/accum_seq_regs.sv
`timescale 1ns/1ps
module accum_seq_regs
    import accum_seq_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned RESET_PC  = 32,
    parameter int unsigned SAVE_ADDR = 2,
    parameter int unsigned ISR_ADDR  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  uop_t              uop,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [OP_W-1:0]   dr_op,
    output logic              dr_ind,
    output logic [OP_W-1:0]   ir_op,
    output logic              zero_q,
    output logic              carry_q,
    output logic              int_en
);

    localparam int unsigned PAD_W = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] dr;
    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] ac;
    logic [DATA_W-1:0] alu_res;
    logic              alu_zero;
    logic              alu_carry;

    accum_seq_alu #(.DATA_W(DATA_W)) u_alu (
        .acc    (ac),
        .opnd   (dr),
        .add_en (uop.ac_from_sum),
        .result (alu_res),
        .zero   (alu_zero),
        .carry  (alu_carry)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mar <= '0;
        end else begin
            unique case (uop.mar_src)
                MAR_FROM_PC:   mar <= pc;
                MAR_FROM_DR:   mar <= dr[ADDR_W-1:0];
                MAR_FROM_IR:   mar <= ir[ADDR_W-1:0];
                MAR_FROM_SAVE: mar <= ADDR_W'(SAVE_ADDR);
                default:       mar <= mar;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               dr <= '0;
        else if (uop.dr_from_mem) dr <= mem_rdata;
        else if (uop.dr_from_pc)  dr <= {{PAD_W{1'b0}}, pc};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pc <= ADDR_W'(RESET_PC);
        else if (uop.pc_vector) pc <= ADDR_W'(ISR_ADDR);
        else if (uop.pc_jump)   pc <= ir[ADDR_W-1:0];
        else if (uop.pc_step)   pc <= pc + ADDR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ir <= '0;
        else if (uop.ir_load)      ir <= dr;
        else if (uop.ir_addr_load) ir[ADDR_W-1:0] <= dr[ADDR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac      <= '0;
            zero_q  <= 1'b0;
            carry_q <= 1'b0;
        end else if (uop.ac_from_dr || uop.ac_from_sum) begin
            ac      <= alu_res;
            zero_q  <= alu_zero;
            carry_q <= alu_carry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          int_en <= 1'b0;
        else if (uop.ie_clr) int_en <= 1'b0;
        else if (uop.ie_set) int_en <= 1'b1;
    end

    assign mem_wdata = uop.wdata_from_dr ? dr : ac;
    assign dr_op     = dr[DATA_W-1 -: OP_W];
    assign dr_ind    = dr[ADDR_W];
    assign ir_op     = ir[DATA_W-1 -: OP_W];

    // R6: the indirect step replaces only the address field
    a_r6_addr_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
        uop.ir_addr_load |=> (ir[ADDR_W-1:0] == $past(dr[ADDR_W-1:0])) &&
                             (ir[DATA_W-1:ADDR_W] == $past(ir[DATA_W-1:ADDR_W])));

    // R3: a LOAD always leaves carry clear
    a_r3_load_clears_carry: assert property (@(posedge clk) disable iff (!rst_n)
        uop.ac_from_dr |=> !carry_q);

endmodule

// File: rtl/accum_seq_core.sv
`timescale 1ns/1ps
module accum_seq_core
    import accum_seq_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned RESET_PC  = 32,
    parameter int unsigned SAVE_ADDR = 2,
    parameter int unsigned ISR_ADDR  = 16,
    localparam int unsigned ADDR_W   = DATA_W - OP_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we
);

    state_e            state;
    uop_t              uop;
    logic [OP_W-1:0]   dr_op;
    logic [OP_W-1:0]   ir_op;
    logic              dr_ind;
    logic              zero_q;
    logic              carry_q;
    logic              int_en;

    accum_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq     (irq),
        .dr_op   (dr_op),
        .dr_ind  (dr_ind),
        .ir_op   (ir_op),
        .zero_f  (zero_q),
        .carry_f (carry_q),
        .int_en  (int_en),
        .state   (state),
        .uop     (uop)
    );

    accum_seq_regs #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .RESET_PC  (RESET_PC),
        .SAVE_ADDR (SAVE_ADDR),
        .ISR_ADDR  (ISR_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .uop       (uop),
        .mem_rdata (mem_rdata),
        .mar       (mem_addr),
        .mem_wdata (mem_wdata),
        .dr_op     (dr_op),
        .dr_ind    (dr_ind),
        .ir_op     (ir_op),
        .zero_q    (zero_q),
        .carry_q   (carry_q),
        .int_en    (int_en)
    );

    assign mem_we = uop.mem_we;

    // R5: a write strobe never lasts two cycles
    a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R8: the entry write goes to the save word
    a_r8_save_target: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_V_WRITE) |-> (mem_we && (mem_addr == ADDR_W'(SAVE_ADDR))));

    // R1: no write while reset is held
    always_comb begin
        if (!rst_n) a_r1_no_write_in_reset: assert (!mem_we);
    end

endmodule

// File: tb/accum_seq_core_bench.sv
`timescale 1ns/1ps
module accum_seq_core_bench;

    localparam int unsigned DW   = 16;
    localparam int unsigned AW   = 11;
    localparam int unsigned SAVE = 2;
    localparam int unsigned ISR  = 16;
    localparam int unsigned BOOT = 32;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq   = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;

    logic [DW-1:0] mem [0:(1<<AW)-1];

    int unsigned cyc;
    int unsigned first_wr;
    int unsigned save_cnt;
    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;

    always #5 clk = ~clk;

    accum_seq_core #(
        .DATA_W(DW), .RESET_PC(BOOT), .SAVE_ADDR(SAVE), .ISR_ADDR(ISR)
    ) u_accum_seq_core (
        .clk(clk), .rst_n(rst_n), .irq(irq),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc      <= 0;
            first_wr <= 0;
            save_cnt <= 0;
        end else begin
            cyc <= cyc + 1;
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                if (first_wr == 0) first_wr <= cyc + 1;
                if (mem_addr == AW'(SAVE)) save_cnt <= save_cnt + 1;
                if (mem_addr == 11'h121) irq <= 1'b0;
            end
        end
    end

    function automatic logic [DW-1:0] enc(input logic [3:0] op, input logic ind,
                                          input logic [AW-1:0] a);
        return {op, ind, a};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int k = 0; k < (1 << AW); k++) mem[k] = '0;
    endtask

    task automatic run(input int unsigned n);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic add_run(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic ind);
        logic [DW:0]   sum;
        logic [AW-1:0] pa;
        logic [AW-1:0] pb;
        hold_reset();
        pa = ind ? 11'h108 : 11'h100;
        pb = ind ? 11'h109 : 11'h101;
        mem[11'h100] = a;      mem[11'h101] = b;
        mem[11'h108] = 16'h0100; mem[11'h109] = 16'h0101;
        mem[11'h110] = 16'h0000; mem[11'h111] = 16'h0001;
        mem[11'h020] = enc(4'h1, ind, pa);
        mem[11'h021] = enc(4'h3, ind, pb);
        mem[11'h022] = enc(4'h2, 1'b0, 11'h102);
        mem[11'h023] = enc(4'h5, 1'b0, 11'h026);
        mem[11'h024] = enc(4'h1, 1'b0, 11'h110);
        mem[11'h025] = enc(4'h4, 1'b0, 11'h027);
        mem[11'h026] = enc(4'h1, 1'b0, 11'h111);
        mem[11'h027] = enc(4'h2, 1'b0, 11'h103);
        mem[11'h028] = enc(4'h1, ind, pa);
        mem[11'h029] = enc(4'h3, ind, pb);
        mem[11'h02A] = enc(4'h6, 1'b0, 11'h02D);
        mem[11'h02B] = enc(4'h1, 1'b0, 11'h110);
        mem[11'h02C] = enc(4'h4, 1'b0, 11'h02E);
        mem[11'h02D] = enc(4'h1, 1'b0, 11'h111);
        mem[11'h02E] = enc(4'h2, 1'b0, 11'h104);
        mem[11'h02F] = enc(4'h4, 1'b0, 11'h02F);
        run(120);
        sum = {1'b0, a} + {1'b0, b};
        check($sformatf("R4 R6 sum %0h+%0h ind=%0d", a, b, ind), mem[11'h102], sum[DW-1:0]);
        check($sformatf("R7 JZ zero %0h+%0h", a, b), mem[11'h103], (sum[DW-1:0] == 0) ? 1 : 0);
        check($sformatf("R4 R7 JC carry %0h+%0h", a, b), mem[11'h104], sum[DW]);
    endtask

    logic [DW-1:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                16'hFFFF, 16'h1234, 16'hEDCC, 16'h00FF};

    initial begin
        #(1_900_000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1, R2, R5: reset state and direct STORE timing
        irq = 1'b0;
        hold_reset();
        check("R1 no write in reset", mem_we, 0);
        mem[11'h100] = 16'hBEEF;
        mem[11'h020] = enc(4'h2, 1'b0, 11'h100);
        mem[11'h021] = enc(4'h4, 1'b0, 11'h021);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 boot address", mem_addr, 11'h020);
        repeat (40) @(negedge clk);
        check("R2 R5 direct store edge", first_wr, 5);
        check("R1 R5 accumulator reset", mem[11'h100], 16'h0000);

        // R6: indirect STORE timing
        hold_reset();
        mem[11'h100] = 16'hBEEF;
        mem[11'h105] = 16'h0100;
        mem[11'h020] = enc(4'h2, 1'b1, 11'h105);
        mem[11'h021] = enc(4'h4, 1'b0, 11'h021);
        run(40);
        check("R6 indirect store edge", first_wr, 8);
        check("R6 indirect store target", mem[11'h100], 16'h0000);

        // R3, R4, R6, R7: sweep of operand pairs
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                add_run(vals[i], vals[j], 1'((i + j) % 2));

        // R3: LOAD sets zero from the value and clears carry
        for (int t = 0; t < 2; t++) begin
            hold_reset();
            mem[11'h100] = (t == 0) ? 16'h0000 : 16'h0005;
            mem[11'h101] = 16'hFFFF; mem[11'h102] = 16'h0001;
            mem[11'h110] = 16'h000A; mem[11'h111] = 16'h000C; mem[11'h112] = 16'h000B;
            mem[11'h020] = enc(4'h1, 1'b0, 11'h101);
            mem[11'h021] = enc(4'h3, 1'b0, 11'h102);
            mem[11'h022] = enc(4'h1, 1'b0, 11'h100);
            mem[11'h023] = enc(4'h6, 1'b0, 11'h027);
            mem[11'h024] = enc(4'h5, 1'b0, 11'h029);
            mem[11'h025] = enc(4'h1, 1'b0, 11'h110);
            mem[11'h026] = enc(4'h4, 1'b0, 11'h02A);
            mem[11'h027] = enc(4'h1, 1'b0, 11'h111);
            mem[11'h028] = enc(4'h4, 1'b0, 11'h02A);
            mem[11'h029] = enc(4'h1, 1'b0, 11'h112);
            mem[11'h02A] = enc(4'h2, 1'b0, 11'h103);
            mem[11'h02B] = enc(4'h4, 1'b0, 11'h02B);
            run(100);
            check($sformatf("R3 load flags value=%0d", t * 5), mem[11'h103],
                  (t == 0) ? 16'h000B : 16'h000A);
        end

        // R10: NOP and unassigned opcodes
        hold_reset();
        mem[11'h100] = 16'h5A5A; mem[11'h101] = 16'h1111;
        mem[11'h020] = enc(4'h1, 1'b0, 11'h100);
        mem[11'h021] = enc(4'h0, 1'b1, 11'h101);
        mem[11'h022] = enc(4'hF, 1'b1, 11'h101);
        mem[11'h023] = enc(4'h8, 1'b0, 11'h101);
        mem[11'h024] = enc(4'h2, 1'b0, 11'h102);
        mem[11'h025] = enc(4'h4, 1'b0, 11'h025);
        run(60);
        check("R10 first write edge", first_wr, 20);
        check("R10 accumulator kept", mem[11'h102], 16'h5A5A);
        check("R10 operand untouched", mem[11'h101], 16'h1111);

        // R9: request ignored while interrupts are disabled
        hold_reset();
        irq = 1'b1;
        mem[11'h100] = 16'h0007;
        mem[11'h020] = enc(4'h1, 1'b0, 11'h100);
        mem[11'h021] = enc(4'h2, 1'b0, 11'h101);
        mem[11'h022] = enc(4'h4, 1'b0, 11'h022);
        run(100);
        check("R9 no entry while disabled", save_cnt, 0);
        check("R9 program unaffected", mem[11'h101], 16'h0007);

        // R8, R9, R6, R7: entry, service, return through the save word
        hold_reset();
        irq = 1'b1;
        mem[11'h120] = 16'h1234; mem[11'h122] = 16'h0005;
        mem[11'h010] = enc(4'h1, 1'b0, 11'h120);
        mem[11'h011] = enc(4'h2, 1'b0, 11'h121);
        mem[11'h012] = enc(4'h7, 1'b0, 11'h000);
        mem[11'h013] = enc(4'h4, 1'b1, 11'h002);
        mem[11'h020] = enc(4'h7, 1'b0, 11'h000);
        mem[11'h021] = enc(4'h1, 1'b0, 11'h122);
        mem[11'h022] = enc(4'h2, 1'b0, 11'h123);
        mem[11'h023] = enc(4'h4, 1'b0, 11'h023);
        run(200);
        check("R9 R8 saved return address", mem[11'h002], 16'h0022);
        check("R8 service routine ran", mem[11'h121], 16'h1234);
        check("R6 R7 return via indirect jump", mem[11'h123], 16'h1234);
        check("R9 single entry", save_cnt, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule